// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core that finishes every instruction in the same clock cycle it is fetched. Each cycle it puts the program counter on an instruction-fetch address port and reads back one instruction word. It decodes the word and reads up to two source registers. An ALU then computes a result or a memory address. In the same cycle the core drives a data-memory port and prepares the register write-back value and the next program counter. All of these take effect together on the next rising clock edge.

The core runs a fixed set of nine instructions:

- word load and word store;
- register-to-register add, subtract, AND, OR and signed set-less-than;
- branch-if-equal;
- an absolute jump.

Both memories are outside the block. The instruction memory and the data-memory read must answer combinationally within the cycle. The data memory writes on the clock edge when the core's write enable is high.

No functional unit is used twice in a cycle. Branches therefore have a separate adder for their target, and jumps build their target by concatenation.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset loads the program counter with the RESET_PC parameter (default 0) on the next rising edge. While reset is high, the data-memory write enable stays low and no register is written.
- R2: Outside branch and jump, the fetch address `imem_addr` advances by 4 on each rising edge.
- R3: Load (opcode 0x23) and store (opcode 0x2B) form the data address as register rs (bits 25:21) plus the sign-extended 16-bit immediate (bits 15:0).
  - Load raises `dmem_re` and writes `dmem_rdata` into register rt (bits 20:16).
  - Store raises `dmem_we` and drives register rt on `dmem_wdata`.
- R4: Opcode 0 with bits 10:6 zero is a register operation. The function field (bits 5:0) selects add 0x20, subtract 0x22, AND 0x24 or OR 0x25. The operation is applied to rs and rt, and the result is written to rd (bits 15:11).
- R5: Function code 0x2A writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R6: Branch-if-equal (opcode 0x04) compares rs with rt.
  - If they are equal, the next fetch address is PC+4 plus the sign-extended immediate shifted left by 2.
  - Otherwise, the next fetch address is PC+4.
- R7: Jump (opcode 0x02) sets the next fetch address to bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits.
- R8: Register 0 always reads as zero, and a write that targets register 0 has no effect.
- R9: `dmem_re` is high only for a load and `dmem_we` only for a store. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (current program counter) |
| imem_instr | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory word address from the ALU |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data returned for `dmem_addr` |
| dmem_re | output | 1 | Data memory read enable |
| dmem_we | output | 1 | Data memory write enable |

## Verification
The bench builds the core with its defaults: a reset address of 0, a 32-bit datapath and 32 registers. Its program and data sit in 64-word memory models, so every address, including the jump target and the branch offsets, falls inside a small window. At these values the program can reach:

- a negative load offset from a nonzero base register;
- an all-ones OR result and a signed comparison against a negative operand;
- both directions of branch-if-equal, a forward jump and a backward branch that parks the core;
- a write aimed at register 0, with its absence shown through a later store.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN  = 32;
    localparam int REGS  = 32;
    localparam int RA_W  = $clog2(REGS);
    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int IMM_W = 16;
    localparam int JT_W  = 26;

    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;   // write a register this cycle
        logic    alu_imm;  // second ALU operand is the immediate
        logic    mem_rd;   // data memory read
        logic    mem_wr;   // data memory write
        logic    wb_mem;   // write-back takes memory data
        logic    dst_rd;   // destination is rd, else rt
        logic    branch;   // conditional branch on equality
        logic    jump;     // absolute jump
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fn;
    logic [4:0]      shamt;

    assign opc   = instr[31:26];
    assign fn    = instr[5:0];
    assign shamt = instr[10:6];

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opc)
            OPC_REG: begin
                if (shamt == '0) begin
                    ctrl.dst_rd = 1'b1;
                    ctrl.reg_wr = 1'b1;
                    case (fn)
                        FN_ADD:  ctrl.alu_op = ALU_ADD;
                        FN_SUB:  ctrl.alu_op = ALU_SUB;
                        FN_AND:  ctrl.alu_op = ALU_AND;
                        FN_OR:   ctrl.alu_op = ALU_OR;
                        FN_SLT:  ctrl.alu_op = ALU_SLT;
                        default: ctrl.reg_wr = 1'b0;
                    endcase
                end
            end
            OPC_LOAD: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.wb_mem  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res,
    output logic            is_zero
);

    always_comb begin
        case (op)
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_SLT: res = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(opb)};
            default: res = '0;
        endcase
    end

    assign is_zero = (res == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int WIDTH = XLEN,
    parameter int DEPTH = REGS,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_val,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b
);

    logic [DEPTH-1:0][WIDTH-1:0] file_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        if (i == 0) begin : g_zero
            // entry 0 is hard-wired to zero and has no storage
            assign file_q[i] = '0;
        end else begin : g_store
            logic [WIDTH-1:0] entry_d, entry_q;

            always_comb begin
                entry_d = entry_q;
                if (wr_en && (wr_idx == AW'(i))) begin
                    entry_d = wr_val;
                end
            end

            always_ff @(posedge clk) begin
                entry_q <= entry_d;
            end

            assign file_q[i] = entry_q;
        end
    end

    assign rd_a = file_q[ra_a];
    assign rd_b = file_q[ra_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_instr,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            dmem_re,
    output logic            dmem_we
);

    core_state_t state_d, state_q;
    ctrl_t       ctrl;

    logic [RA_W-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
    logic [XLEN-1:0] src_a, src_b, imm_ext, alu_b, alu_res, wb_val;
    logic [XLEN-1:0] pc_plus4, br_target, jmp_target;
    logic            alu_zero, rf_we;

    // instruction fields
    assign rs_idx  = imem_instr[25:21];
    assign rt_idx  = imem_instr[20:16];
    assign rd_idx  = imem_instr[15:11];
    assign imm_ext = {{(XLEN-IMM_W){imem_instr[IMM_W-1]}}, imem_instr[IMM_W-1:0]};

    sc_decoder u_dec (
        .instr (imem_instr),
        .ctrl  (ctrl)
    );

    assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;
    assign rf_we   = ctrl.reg_wr & ~rst;

    sc_regfile #(
        .WIDTH (XLEN),
        .DEPTH (REGS)
    ) u_rf (
        .clk    (clk),
        .ra_a   (rs_idx),
        .ra_b   (rt_idx),
        .wr_en  (rf_we),
        .wr_idx (dst_idx),
        .wr_val (wb_val),
        .rd_a   (src_a),
        .rd_b   (src_b)
    );

    assign alu_b = ctrl.alu_imm ? imm_ext : src_b;

    sc_alu u_alu (
        .opa     (src_a),
        .opb     (alu_b),
        .op      (ctrl.alu_op),
        .res     (alu_res),
        .is_zero (alu_zero)
    );

    assign wb_val = ctrl.wb_mem ? dmem_rdata : alu_res;

    // data memory port
    assign dmem_addr  = alu_res;
    assign dmem_wdata = src_b;
    assign dmem_re    = ctrl.mem_rd & ~rst;
    assign dmem_we    = ctrl.mem_wr & ~rst;

    // next-address logic: separate adders for the increment and the branch target
    assign pc_plus4   = state_q.pc + XLEN'(4);
    assign br_target  = pc_plus4 + (imm_ext << 2);
    assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], imem_instr[JT_W-1:0], 2'b00};

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = RESET_PC;
        end else if (ctrl.jump) begin
            state_d.pc = jmp_target;
        end else if (ctrl.branch && alu_zero) begin
            state_d.pc = br_target;
        end else begin
            state_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign imem_addr = state_q.pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_instr,
    input logic [XLEN-1:0] dmem_wdata,
    input logic            dmem_re,
    input logic            dmem_we
);

    logic [OP_W-1:0] opc;
    assign opc = imem_instr[31:26];

    // R1: reset lands the fetch address on the reset value
    p_reset_pc_r1: assert property (@(posedge clk) rst |=> (imem_addr == RESET_PC));

    // R1: no memory write while reset is held
    p_no_write_in_reset_r1: assert property (@(posedge clk) rst |-> !dmem_we);

    // R2: sequential flow for anything but branch and jump
    p_seq_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_BEQ && opc != OPC_JUMP) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R6: branch goes either to the fall-through or to the offset target
    p_beq_target_r6: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ) |=>
            ((imem_addr == $past(imem_addr) + 32'd4) ||
             (imem_addr == $past(imem_addr) + 32'd4 +
                 {{14{$past(imem_instr[15])}}, $past(imem_instr[15:0]), 2'b00})));

    // R7: jump target from the upper nibble of PC+4 and the 26-bit field
    p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JUMP) |=>
            (imem_addr[27:0] == {$past(imem_instr[25:0]), 2'b00}));

    // R8: a store of register 0 always carries zero
    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (dmem_we && imem_instr[20:16] == 5'd0) |-> (dmem_wdata == '0));

    // R9: read and write enables are exclusive
    p_rw_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(dmem_re && dmem_we));

endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_instr (imem_instr),
    .dmem_wdata (dmem_wdata),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;

    localparam time CLK_HALF = 10ns;   // 50 MHz
    localparam int  MEM_WORDS = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_instr, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_re, dmem_we;

    int checks = 0;
    int failures = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    logic [31:0] imem [MEM_WORDS];
    logic [31:0] dmem [MEM_WORDS];

    typedef struct {
        logic [31:0] pc;
        logic        re;
        string       req;
    } fetch_item_t;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        string       req;
    } store_item_t;

    fetch_item_t fetch_q[$];
    store_item_t store_q[$];

    always #(CLK_HALF) clk = ~clk;

    sc_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_instr (imem_instr),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_re    (dmem_re),
        .dmem_we    (dmem_we)
    );

    assign imem_instr = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, tgt[25:0]};
    endfunction

    task automatic push_fetch(int word, bit re, string req);
        fetch_item_t it;
        it.pc = 32'(word * 4);
        it.re = re;
        it.req = req;
        fetch_q.push_back(it);
    endtask

    task automatic push_store(logic [31:0] addr, logic [31:0] data, string req);
        store_item_t it;
        it.addr = addr;
        it.data = data;
        it.req = req;
        store_q.push_back(it);
    endtask

    // monitor: compares the design against the scoreboard queues
    always @(negedge clk) begin
        if (running) begin
            if (fetch_q.size() != 0) begin
                fetch_item_t f;
                f = fetch_q.pop_front();
                check(imem_addr == f.pc, f.req, "fetch address", imem_addr, f.pc);
                check(dmem_re == f.re, "R9", "read enable", 32'(dmem_re), 32'(f.re));
            end
            if (dmem_we) begin
                if (store_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected store", dmem_addr, 32'hFFFF_FFFF);
                end else begin
                    store_item_t s;
                    s = store_q.pop_front();
                    check(dmem_addr == s.addr, s.req, "store address", dmem_addr, s.addr);
                    check(dmem_wdata == s.data, s.req, "store data", dmem_wdata, s.data);
                end
            end
        end
    end

    // driver
    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        dmem[0] = 32'h0000_0007;
        dmem[1] = 32'hFFFF_FFFD;

        imem[0]  = enc_i(6'h23, 0, 1, 0);          // r1 = 7
        imem[1]  = enc_i(6'h23, 0, 2, 4);          // r2 = -3
        imem[2]  = enc_r(1, 2, 3, 6'h20);          // r3 = 4
        imem[3]  = enc_i(6'h2B, 0, 3, 64);
        imem[4]  = enc_r(1, 2, 4, 6'h22);          // r4 = 10
        imem[5]  = enc_i(6'h2B, 0, 4, 68);
        imem[6]  = enc_r(1, 2, 5, 6'h24);          // r5 = 5
        imem[7]  = enc_i(6'h2B, 0, 5, 72);
        imem[8]  = enc_r(1, 2, 6, 6'h25);          // r6 = all ones
        imem[9]  = enc_i(6'h2B, 0, 6, 76);
        imem[10] = enc_r(2, 1, 7, 6'h2A);          // r7 = (-3 < 7) = 1
        imem[11] = enc_i(6'h2B, 0, 7, 80);
        imem[12] = enc_r(1, 2, 8, 6'h2A);          // r8 = (7 < -3) = 0
        imem[13] = enc_i(6'h2B, 0, 8, 84);
        imem[14] = enc_r(1, 1, 0, 6'h20);          // write to r0, ignored
        imem[15] = enc_i(6'h2B, 0, 0, 88);
        imem[16] = enc_i(6'h23, 3, 9, -4);         // r9 = mem[4-4] = 7
        imem[17] = enc_i(6'h2B, 0, 9, 92);
        imem[18] = enc_i(6'h04, 1, 2, 5);          // not taken
        imem[19] = enc_i(6'h2B, 0, 1, 96);
        imem[20] = enc_i(6'h04, 1, 9, 2);          // taken to word 23
        imem[21] = enc_i(6'h2B, 0, 2, 100);        // skipped
        imem[22] = enc_i(6'h2B, 0, 2, 100);        // skipped
        imem[23] = enc_j(26);                      // jump to word 26
        imem[24] = enc_i(6'h2B, 0, 2, 104);        // skipped
        imem[25] = enc_i(6'h2B, 0, 2, 104);        // skipped
        imem[26] = enc_i(6'h2B, 3, 3, 96);         // addr 100, data 4
        imem[27] = enc_i(6'h04, 0, 0, -1);         // branch to itself

        // expected fetch sequence
        for (int w = 0; w <= 20; w++) begin
            push_fetch(w, (w == 0 || w == 1 || w == 16), "R2");
        end
        push_fetch(23, 1'b0, "R6");
        push_fetch(26, 1'b0, "R7");
        for (int k = 0; k < 5; k++) push_fetch(27, 1'b0, "R6");

        // expected stores
        push_store(32'd64,  32'd4,          "R4");
        push_store(32'd68,  32'd10,         "R4");
        push_store(32'd72,  32'd5,          "R4");
        push_store(32'd76,  32'hFFFF_FFFF,  "R4");
        push_store(32'd80,  32'd1,          "R5");
        push_store(32'd84,  32'd0,          "R5");
        push_store(32'd88,  32'd0,          "R8");
        push_store(32'd92,  32'd7,          "R3");
        push_store(32'd96,  32'd7,          "R6");
        push_store(32'd100, 32'd4,          "R3");

        // reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'd0, "R1", "reset fetch address", imem_addr, 32'd0);
        check(dmem_we == 1'b0, "R1", "write enable in reset", 32'(dmem_we), 32'd0);

        @(posedge clk);
        #2;
        rst = 1'b0;
        running = 1'b1;

        wait (fetch_q.size() == 0);
        @(posedge clk);
        #2;
        running = 1'b0;

        check(store_q.size() == 0, "R6", "stores left unseen", 32'(store_q.size()), 32'd0);
        check(dmem[16] == 32'd4, "R3", "memory word 64", dmem[16], 32'd4);
        check(dmem[25] == 32'd4, "R7", "memory word 100", dmem[25], 32'd4);
        check(dmem[26] == 32'd0, "R7", "skipped store word 104", dmem[26], 32'd0);

        // reset from a running state
        rst = 1'b1;
        @(negedge clk);
        check(dmem_we == 1'b0, "R1", "write enable with reset", 32'(dmem_we), 32'd0);
        @(negedge clk);
        check(imem_addr == 32'd0, "R1", "fetch address after reset", imem_addr, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_HALF * 2 * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=%h expected=%h", imem_addr, 32'd108);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule